// File: doc/BRIEF.md
# Serial Flash Command Phase and Lane Width Tracker

This block watches the byte stream that a flash controller shifts out to a serial NOR flash. Each byte sent while the chip select is active counts as one step. The first byte of a selection is taken as the opcode and decoded. The decode gives the address length, the number of dummy bytes, and the lane width the command uses after the opcode, and says whether that width applies at once or only once the address and dummy bytes have gone out. From then on the tracker walks the command through its address, dummy and data phases.

Its outputs drive the serializer for the next byte:
- the lane width (1, 2 or 4 bits per clock);
- the number of serial clocks that byte takes (8 divided by the width);
- whether the byte is a dummy;
- whether data bytes are spread bit-wise across the lanes.

The tracker also runs a receive-discard counter. It is loaded each time the chip select asserts and tells the receive path to drop captured bytes until the programmed number of clock cycles has passed.

The parameter `QUAD_EN` selects a build with or without the four-lane commands. Without it, four-lane opcodes decode as unknown.

Top module: `flash_cmd_tracker`

## Requirements
- R1: After reset, and in the cycle after any cycle with `cs_active` low, the phase is CHECK (0) and the width is 1. Any scheduled width change is cancelled.
- R2: An opcode the decoder does not know moves the phase to NONE (4). Later bytes leave the phase at NONE and the width at 1 until `cs_active` drops.
- R3: Address length is 4 bytes for opcodes 0x13, 0x0C, 0x3C, 0x6C, 0xBC, 0xEC, 0x12 and 0x34. Every other known opcode uses 4 bytes when `ext_addr` is 1 in the opcode's cycle, and 3 bytes otherwise.
- R4: Dummy byte counts are as follows:
  - 0 for 0x03, 0x13, 0x02, 0x12, 0xA2, 0x32 and 0x34;
  - 1 for 0x0B, 0x3B, 0x3C, 0x6B and 0x6C;
  - 2 for 0x0C, 0xBB and 0xBC;
  - 5 for 0xEB and 0xEC.
- R5: After a known opcode the phase is ADDR (1) for the address bytes, then DUMMY (2) for the dummy bytes, then DATA (3). `stripe_en` is high only in DATA.
- R6: The output-read and program opcodes switch the width only after the address and dummy bytes have been sent. The width becomes 2 for 0x3B, 0x3C and 0xA2, and 4 for 0x6B, 0x6C, 0x32 and 0x34.
- R7: The dual IO reads (0xBB, 0xBC) set width 2, and the quad IO reads (0xEB, 0xEC) set width 4, in the cycle after the opcode, so the address is sent wide.
- R8: `bit_clocks` equals 8 divided by the width, and `dummy_flag` is high exactly in the DUMMY phase.
- R9: On the cycle `cs_active` rises, the discard counter loads `discard_init`. Each later byte lowers it by `bit_clocks`, stopping at zero. `rx_drop` is high while the counter is nonzero.
- R10: A cycle with `byte_sent` low, or with `cs_active` low, changes neither phase nor width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_sent | input | 1 | One byte was shifted out this cycle |
| byte_data | input | 8 | Value of the byte that was sent |
| cs_active | input | 1 | Chip select asserted |
| ext_addr | input | 1 | Use 4-byte addresses for opcodes without a fixed length |
| discard_init | input | DISC_W | Clock count to discard after chip select asserts |
| lane_width | output | 3 | Lane width for the next byte: 1, 2 or 4 |
| phase | output | 3 | CHECK=0, ADDR=1, DUMMY=2, DATA=3, NONE=4 |
| dummy_flag | output | 1 | The next byte is a dummy |
| stripe_en | output | 1 | The next byte is data and is striped across lanes |
| bit_clocks | output | 4 | Serial clocks for the next byte |
| rx_drop | output | 1 | Captured bytes are discarded |

## Verification
The assertions assume two things about the inputs. First, `byte_sent` only means something while `cs_active` is high. Second, `cs_active` comes from the controller, so it can drop in any phase. The stimulus changes inputs only on the falling clock edge. Each command is framed by one cycle with chip select low, and the stimulus both drops chip select in the middle of a command and sends strobes while it is low. Opcodes come from the decoded set, plus one that is not decoded, with `ext_addr` set both ways.

// File: rtl/fct_pkg.sv
package fct_pkg;
   typedef enum logic [2:0] {
      PH_CHECK = 3'd0,
      PH_ADDR  = 3'd1,
      PH_DUMMY = 3'd2,
      PH_DATA  = 3'd3,
      PH_NONE  = 3'd4
   } phase_e;

   typedef struct packed {
      logic       known;    // opcode recognised
      logic       addr4;    // fixed 4-byte address form
      logic [2:0] dummies;  // dummy byte count
      logic [2:0] width;    // lane width once switched
      logic       at_once;  // width applies right after opcode
   } op_info_t;
endpackage

// File: rtl/fct_opcode_decode.sv
module fct_opcode_decode
   import fct_pkg::*;
#(
   parameter bit QUAD_EN = 1'b1
) (
   input  logic [7:0] op,
   output op_info_t   info
);
   op_info_t full;

   always_comb begin
      full = '0;
      full.width = 3'd1;
      unique case (op)
         8'h03: begin full.known = 1'b1; end
         8'h13: begin full.known = 1'b1; full.addr4 = 1'b1; end
         8'h0B: begin full.known = 1'b1; full.dummies = 3'd1; end
         8'h0C: begin full.known = 1'b1; full.addr4 = 1'b1; full.dummies = 3'd2; end
         8'h3B: begin full.known = 1'b1; full.dummies = 3'd1; full.width = 3'd2; end
         8'h3C: begin full.known = 1'b1; full.addr4 = 1'b1; full.dummies = 3'd1; full.width = 3'd2; end
         8'h6B: begin full.known = 1'b1; full.dummies = 3'd1; full.width = 3'd4; end
         8'h6C: begin full.known = 1'b1; full.addr4 = 1'b1; full.dummies = 3'd1; full.width = 3'd4; end
         8'hBB: begin full.known = 1'b1; full.dummies = 3'd2; full.width = 3'd2; full.at_once = 1'b1; end
         8'hBC: begin full.known = 1'b1; full.addr4 = 1'b1; full.dummies = 3'd2; full.width = 3'd2; full.at_once = 1'b1; end
         8'hEB: begin full.known = 1'b1; full.dummies = 3'd5; full.width = 3'd4; full.at_once = 1'b1; end
         8'hEC: begin full.known = 1'b1; full.addr4 = 1'b1; full.dummies = 3'd5; full.width = 3'd4; full.at_once = 1'b1; end
         8'h02: begin full.known = 1'b1; end
         8'h12: begin full.known = 1'b1; full.addr4 = 1'b1; end
         8'hA2: begin full.known = 1'b1; full.width = 3'd2; end
         8'h32: begin full.known = 1'b1; full.width = 3'd4; end
         8'h34: begin full.known = 1'b1; full.addr4 = 1'b1; full.width = 3'd4; end
         default: full.known = 1'b0;
      endcase
   end

   generate
      if (QUAD_EN) begin : g_quad
         assign info = full;
      end else begin : g_noquad
         always_comb begin
            info = full;
            if (full.width == 3'd4) begin
               info = '0;
               info.width = 3'd1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/fct_phase_seq.sv
module fct_phase_seq
   import fct_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             clear,
   input  op_info_t         info,
   input  logic [CNT_W-1:0] alen,
   output phase_e           phase
);
   logic [CNT_W-1:0] cnt;
   logic [2:0]       dum;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         phase <= PH_CHECK;
         cnt   <= '0;
         dum   <= '0;
      end else if (step) begin
         unique case (phase)
            PH_CHECK: begin
               if (!info.known) begin
                  phase <= PH_NONE;
               end else begin
                  phase <= PH_ADDR;
                  cnt   <= alen;
                  dum   <= info.dummies;
               end
            end
            PH_ADDR: begin
               if (cnt == CNT_W'(1)) begin
                  if (dum == 3'd0) begin
                     phase <= PH_DATA;
                  end else begin
                     phase <= PH_DUMMY;
                     cnt   <= CNT_W'(dum);
                  end
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            PH_DUMMY: begin
               if (cnt == CNT_W'(1)) phase <= PH_DATA;
               else                  cnt   <= cnt - CNT_W'(1);
            end
            default: phase <= phase;
         endcase
      end
   end

   // R1: a deselect returns the sequencer to opcode checking
   assert_cs_drop_check_R1: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> phase == PH_CHECK);
   // R2: the pass-through state is left only by a deselect
   assert_none_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_NONE && !clear) |=> phase == PH_NONE);
endmodule

// File: rtl/fct_width_sched.sv
module fct_width_sched
   import fct_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             clear,
   input  logic             is_opcode,
   input  op_info_t         info,
   input  logic [CNT_W-1:0] alen,
   output logic [2:0]       width
);
   logic [CNT_W-1:0] pend_cnt;
   logic [2:0]       pend_w;
   logic [CNT_W-1:0] delay;

   assign delay = alen + CNT_W'(info.dummies);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         width    <= 3'd1;
         pend_cnt <= '0;
         pend_w   <= 3'd1;
      end else if (step) begin
         if (is_opcode) begin
            if (info.known && info.at_once) begin
               width <= info.width;
            end else if (info.known && info.width != 3'd1) begin
               pend_w   <= info.width;
               pend_cnt <= delay;
            end
         end else if (pend_cnt != '0) begin
            pend_cnt <= pend_cnt - CNT_W'(1);
            if (pend_cnt == CNT_W'(1)) width <= pend_w;
         end
      end
   end

   // R10: no byte step, no width movement
   assert_idle_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clear) |=> $stable(width));
   // R8: width is always a legal lane count
   assert_width_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(width) && width != 3'd0 && !width[2:0][0] || width == 3'd1);
endmodule

// File: rtl/fct_rx_discard.sv
module fct_rx_discard #(
   parameter int DISC_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_active,
   input  logic              byte_sent,
   input  logic [DISC_W-1:0] init,
   input  logic [3:0]        bit_clocks,
   output logic              drop
);
   logic              cs_q;
   logic [DISC_W-1:0] cnt;
   logic [DISC_W-1:0] dec;

   assign dec  = DISC_W'(bit_clocks);
   assign drop = (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q <= 1'b0;
         cnt  <= '0;
      end else begin
         cs_q <= cs_active;
         if (cs_active && !cs_q) begin
            cnt <= init;
         end else if (cs_active && byte_sent && drop) begin
            cnt <= (cnt > dec) ? cnt - dec : '0;
         end
      end
   end

   // R9: within a selection the counter only counts down
   assert_discard_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_q && cs_active) |=> cnt <= $past(cnt));
endmodule

// File: rtl/flash_cmd_tracker.sv
module flash_cmd_tracker
   import fct_pkg::*;
#(
   parameter int STD_ADDR_BYTES = 3,
   parameter int EXT_ADDR_BYTES = 4,
   parameter int CNT_W          = 4,
   parameter int DISC_W         = 7,
   parameter bit QUAD_EN        = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_sent,
   input  logic [7:0]        byte_data,
   input  logic              cs_active,
   input  logic              ext_addr,
   input  logic [DISC_W-1:0] discard_init,
   output logic [2:0]        lane_width,
   output logic [2:0]        phase,
   output logic              dummy_flag,
   output logic              stripe_en,
   output logic [3:0]        bit_clocks,
   output logic              rx_drop
);
   localparam int MAX_DELAY = EXT_ADDR_BYTES + 5;

   generate
      if (MAX_DELAY >= (1 << CNT_W)) begin : g_bad_cnt
         $error("CNT_W too narrow for address plus dummy count");
      end
      if (STD_ADDR_BYTES < 1 || EXT_ADDR_BYTES < STD_ADDR_BYTES) begin : g_bad_addr
         $error("address byte parameters inconsistent");
      end
      if (DISC_W < 4) begin : g_bad_disc
         $error("DISC_W must hold at least 8");
      end
   endgenerate

   op_info_t         info;
   phase_e           ph;
   logic             step;
   logic             clear;
   logic [CNT_W-1:0] alen;

   assign step  = byte_sent && cs_active;
   assign clear = !cs_active;
   assign alen  = (info.addr4 || ext_addr) ? CNT_W'(EXT_ADDR_BYTES) : CNT_W'(STD_ADDR_BYTES);

   fct_opcode_decode #(.QUAD_EN(QUAD_EN)) u_dec (
      .op   (byte_data),
      .info (info)
   );

   fct_phase_seq #(.CNT_W(CNT_W)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .clear (clear),
      .info  (info),
      .alen  (alen),
      .phase (ph)
   );

   fct_width_sched #(.CNT_W(CNT_W)) u_wid (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .clear     (clear),
      .is_opcode (ph == PH_CHECK),
      .info      (info),
      .alen      (alen),
      .width     (lane_width)
   );

   always_comb begin
      unique case (lane_width)
         3'd2:    bit_clocks = 4'd4;
         3'd4:    bit_clocks = 4'd2;
         default: bit_clocks = 4'd8;
      endcase
   end

   fct_rx_discard #(.DISC_W(DISC_W)) u_disc (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_active  (cs_active),
      .byte_sent  (byte_sent),
      .init       (discard_init),
      .bit_clocks (bit_clocks),
      .drop       (rx_drop)
   );

   assign phase      = ph;
   assign dummy_flag = (ph == PH_DUMMY);
   assign stripe_en  = (ph == PH_DATA);

   // R2: pass-through traffic is always single lane
   assert_none_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_NONE) |-> lane_width == 3'd1);
   // R1: deselect also drops the width back to one lane
   assert_cs_drop_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_active |=> lane_width == 3'd1);
endmodule

// File: tb/flash_cmd_tracker_test.sv
module flash_cmd_tracker_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_sent = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic       cs_active = 1'b0;
   logic       ext_addr = 1'b0;
   logic [6:0] discard_init = 7'd0;
   logic [2:0] lane_width;
   logic [2:0] phase;
   logic       dummy_flag;
   logic       stripe_en;
   logic [3:0] bit_clocks;
   logic       rx_drop;

   int n_checks = 0;
   int n_fails  = 0;

   always #5 clk = ~clk;

   flash_cmd_tracker uut (
      .clk(clk), .rst_n(rst_n), .byte_sent(byte_sent), .byte_data(byte_data),
      .cs_active(cs_active), .ext_addr(ext_addr), .discard_init(discard_init),
      .lane_width(lane_width), .phase(phase), .dummy_flag(dummy_flag),
      .stripe_en(stripe_en), .bit_clocks(bit_clocks), .rx_drop(rx_drop)
   );

   typedef struct packed {
      logic [7:0] op;
      logic       ext;
      logic [2:0] alen;
      logic [2:0] dum;
      logic [2:0] wid;
      logic       imm;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{8'h03, 1'b0, 3'd3, 3'd0, 3'd1, 1'b0},
      '{8'h03, 1'b1, 3'd4, 3'd0, 3'd1, 1'b0},
      '{8'h13, 1'b0, 3'd4, 3'd0, 3'd1, 1'b0},
      '{8'h0B, 1'b0, 3'd3, 3'd1, 3'd1, 1'b0},
      '{8'h0C, 1'b0, 3'd4, 3'd2, 3'd1, 1'b0},
      '{8'h3B, 1'b0, 3'd3, 3'd1, 3'd2, 1'b0},
      '{8'h3C, 1'b0, 3'd4, 3'd1, 3'd2, 1'b0},
      '{8'h6B, 1'b1, 3'd4, 3'd1, 3'd4, 1'b0},
      '{8'h6C, 1'b0, 3'd4, 3'd1, 3'd4, 1'b0},
      '{8'hBB, 1'b0, 3'd3, 3'd2, 3'd2, 1'b1},
      '{8'hBC, 1'b0, 3'd4, 3'd2, 3'd2, 1'b1},
      '{8'hEB, 1'b0, 3'd3, 3'd5, 3'd4, 1'b1},
      '{8'hEC, 1'b1, 3'd4, 3'd5, 3'd4, 1'b1},
      '{8'h02, 1'b0, 3'd3, 3'd0, 3'd1, 1'b0},
      '{8'h12, 1'b0, 3'd4, 3'd0, 3'd1, 1'b0},
      '{8'hA2, 1'b0, 3'd3, 3'd0, 3'd2, 1'b0},
      '{8'h32, 1'b0, 3'd3, 3'd0, 3'd4, 1'b0},
      '{8'h34, 1'b0, 3'd4, 3'd0, 3'd4, 1'b0}
   };

   task automatic chk(input string tag, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fails++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // drive one byte strobe; return at the following falling edge
   task automatic send(input logic [7:0] b);
      @(negedge clk);
      byte_sent = 1'b1;
      byte_data = b;
      @(negedge clk);
      byte_sent = 1'b0;
      byte_data = 8'h00;
   endtask

   task automatic deselect();
      @(negedge clk);
      cs_active = 1'b0;
      @(negedge clk);
      cs_active = 1'b1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 reset phase", phase, 0);
      chk("R1 reset width", lane_width, 1);
      chk("R8 reset clocks", bit_clocks, 8);
      cs_active = 1'b1;

      for (int v = 0; v < NV; v++) begin
         vec_t e = VECS[v];
         int tot = int'(e.alen) + int'(e.dum);
         deselect();
         chk("R1 check after deselect", phase, 0);
         chk("R1 width after deselect", lane_width, 1);
         ext_addr = e.ext;
         send(e.op);
         ext_addr = 1'b0;
         chk("R5 phase after opcode", phase, 1);
         chk("R7 width after opcode", lane_width, e.imm ? int'(e.wid) : 1);
         for (int k = 1; k <= tot; k++) begin
            int ep;
            int ew;
            send(8'h5A);
            ep = (k < int'(e.alen)) ? 1 : ((k < tot) ? 2 : 3);
            ew = e.imm ? int'(e.wid) : ((k == tot) ? int'(e.wid) : 1);
            chk("R3 R4 R5 phase", phase, ep);
            chk("R6 width", lane_width, ew);
            chk("R8 dummy flag", dummy_flag, (ep == 2) ? 1 : 0);
         end
         for (int k = 0; k < 2; k++) begin
            send(8'hC3);
            chk("R5 data phase", phase, 3);
            chk("R5 stripe", stripe_en, 1);
            chk("R8 clocks", bit_clocks, 8 / int'(e.wid));
         end
      end

      // R2: unknown opcode passes through at one lane
      deselect();
      send(8'h9F);
      chk("R2 none phase", phase, 4);
      send(8'hEB);
      chk("R2 still none", phase, 4);
      chk("R2 width one", lane_width, 1);
      chk("R2 no stripe", stripe_en, 0);

      // R1: deselect mid-command cancels a scheduled width change
      deselect();
      send(8'h3B);
      send(8'h00);
      send(8'h00);
      deselect();
      send(8'h03);
      send(8'h00);
      send(8'h00);
      chk("R1 pending cancelled width", lane_width, 1);
      chk("R1 pending cancelled phase", phase, 1);

      // R10: strobe low, and strobe with cs low, have no effect
      deselect();
      @(negedge clk);
      byte_data = 8'hEB;
      @(negedge clk);
      chk("R10 no strobe phase", phase, 0);
      chk("R10 no strobe width", lane_width, 1);
      cs_active = 1'b0;
      send(8'hEB);
      chk("R10 cs low phase", phase, 0);
      chk("R10 cs low width", lane_width, 1);

      // R9: discard counter, width dependent decrement
      discard_init = 7'd10;
      @(negedge clk);
      cs_active = 1'b1;
      @(negedge clk);
      chk("R9 loaded drop", rx_drop, 1);
      send(8'hEB);
      chk("R9 drop after 8 clocks", rx_drop, 1);
      send(8'h00);
      chk("R9 drop after 2 more", rx_drop, 0);
      // R9: saturation at zero
      discard_init = 7'd3;
      deselect();
      @(negedge clk);
      chk("R9 reload", rx_drop, 1);
      send(8'h03);
      chk("R9 saturate", rx_drop, 0);
      discard_init = 7'd0;

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule